// File: doc/BRIEF.md
# Cache Injection Window Table

This block sits beside a private cache and lets it take in shared lines that it never missed on. Software running on the consumer processor sets up address windows in a small table. Each window is opened in two steps, first the low bound and then the high bound, and is closed by naming its low bound again. Bounds are line addresses, and both ends are inclusive.

While the windows are open, the block watches the data transactions on the shared bus. These are read replies sent to other processors, and update or store-update pushes from a producer. When such a transaction lands inside any open window and the local cache holds no valid copy of the line, the block captures the whole line. It then hands the line to the cache fill port as four 64-bit beats, and the cache installs it in Shared state. If the local copy is already Shared, an update or store-update refreshes its data. A read reply in that case leaves the line alone.

The window lookup is combinational in the snoop cycle. The fill request is registered, so it appears on the fill port one cycle after the snoop.

Top module: `inj_window_table`

## Requirements
- R1: After reset no window is open, no pending low bound is held, `fill_valid_o` is 0 and `overflow_o` is 0.
- R2: Commands use `cmd_op_i` codes 1 (open-low), 2 (open-high) and 3 (close); code 0 does nothing. An open-low stores a pending low bound, and a later open-low replaces it. An open-high that follows makes the window [low, high] valid. `snoop_hit_o` is 1 exactly when `snoop_valid_i` is 1 and some valid window satisfies low <= `snoop_addr_i` <= high.
- R3: An open-high with no pending low bound changes no window and does not set the overflow flag.
- R4: An open-high that finds every table entry in use is dropped and sets `overflow_o`. The flag then stays 1 until reset.
- R5: A close command invalidates every valid window whose low bound equals `cmd_addr_i`, and the freed entries can be used again.
- R6: A read reply (`snoop_kind_i`=0) with `snoop_own_i`=0 that hits the table, while `line_state_i` is 0 (invalid or absent), starts a fill with `fill_refresh_o`=0.
- R7: An update (kind 1) or store-update (kind 2) with `snoop_own_i`=0 that hits the table starts a fill. If the local state is 0, the fill has `fill_refresh_o`=0. If the local state is 1 (Shared), the fill has `fill_refresh_o`=1.
- R8: No fill starts in any of these cases: a table miss, `snoop_own_i`=1, kind 3, local state 2 or 3 (exclusive or modified), or a read reply while the local state is Shared.
- R9: A fill is presented in the cycle after its snoop. It carries beats 0 to 3 in order, where beat k is `snoop_line_i[64k+63:64k]`. Each beat is held while `fill_ready_i` is 0, and `fill_last_o` marks beat 3.
- R10: A qualifying snoop that arrives while a fill is being presented, including during its last beat, is dropped, and the fill in progress is left unchanged.
- R11: A snoop is matched against the table as it stood before any command given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Window command valid |
| cmd_op_i | input | 2 | Window command code |
| cmd_addr_i | input | LA_W | Line address carried by the command |
| snoop_valid_i | input | 1 | Bus data transaction present this cycle |
| snoop_kind_i | input | 2 | 0 read reply, 1 update, 2 store-update, 3 other |
| snoop_own_i | input | 1 | Transaction was issued for the local processor |
| snoop_addr_i | input | LA_W | Line address of the transaction |
| snoop_line_i | input | BEATS*BEAT_W | Full line data of the transaction |
| line_state_i | input | 2 | Local copy state: 0 invalid, 1 shared, 2 exclusive, 3 modified |
| snoop_hit_o | output | 1 | Snooped address lies in an open window |
| fill_valid_o | output | 1 | Fill beat valid |
| fill_ready_i | input | 1 | Cache accepts the fill beat |
| fill_line_addr_o | output | LA_W | Line address being filled |
| fill_beat_o | output | $clog2(BEATS) | Index of the current beat |
| fill_data_o | output | BEAT_W | Beat data |
| fill_last_o | output | 1 | Current beat is the last one |
| fill_refresh_o | output | 1 | Fill refreshes a Shared line rather than installing a new one |
| overflow_o | output | 1 | Sticky flag: an open request was dropped because the table was full |

## Verification
The bench builds the block with four windows and 16-bit line addresses, and keeps the default line of four 64-bit beats. With only four entries the table fills after a few commands, so the dropped open, the sticky overflow flag and the reuse of an entry freed by a close can all be reached quickly. The short addresses keep the window edges easy to read, and the probes go one line below, at and one line above each bound. The fill port is driven both with a ready that stays high and with a ready that toggles, so that beat holding and the drop of snoops during a busy fill both occur.

// File: rtl/iwt_pkg.sv
package iwt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_OPEN_LO = 2'd1,
    CMD_OPEN_HI = 2'd2,
    CMD_CLOSE   = 2'd3
  } win_cmd_e;

  typedef enum logic [1:0] {
    SNP_RD_REPLY  = 2'd0,
    SNP_UPDATE    = 2'd1,
    SNP_STORE_UPD = 2'd2,
    SNP_OTHER     = 2'd3
  } snoop_kind_e;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_e;
endpackage

// File: rtl/iwt_first_free.sv
module iwt_first_free #(
  parameter int N = 128
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (free_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/iwt_win_array.sv
module iwt_win_array
  import iwt_pkg::*;
#(
  parameter int NUM_WIN = 128,
  parameter int LA_W    = 27
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_op_i,
  input  logic [LA_W-1:0] cmd_addr_i,
  input  logic [LA_W-1:0] probe_addr_i,
  output logic            probe_hit_o,
  output logic            overflow_o
);
  logic [NUM_WIN-1:0] valid_q;
  logic [LA_W-1:0]    lo_q [NUM_WIN];
  logic [LA_W-1:0]    hi_q [NUM_WIN];
  logic               pend_v_q;
  logic [LA_W-1:0]    pend_lo_q;
  logic               ovf_q;

  logic [NUM_WIN-1:0] in_rng, close_match, grant;
  logic               any_free;
  logic               is_lo, is_hi, is_close, do_alloc, do_drop;

  assign is_lo    = cmd_valid_i && (win_cmd_e'(cmd_op_i) == CMD_OPEN_LO);
  assign is_hi    = cmd_valid_i && (win_cmd_e'(cmd_op_i) == CMD_OPEN_HI);
  assign is_close = cmd_valid_i && (win_cmd_e'(cmd_op_i) == CMD_CLOSE);
  assign do_alloc = is_hi && pend_v_q && any_free;
  assign do_drop  = is_hi && pend_v_q && !any_free;

  iwt_first_free #(.N(NUM_WIN)) u_free (
    .free_i  (~valid_q),
    .grant_o (grant),
    .any_o   (any_free)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_ent
    assign in_rng[i]      = valid_q[i] && (lo_q[i] <= probe_addr_i) && (probe_addr_i <= hi_q[i]);
    assign close_match[i] = valid_q[i] && (lo_q[i] == cmd_addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        lo_q[i]    <= '0;
        hi_q[i]    <= '0;
      end else if (do_alloc && grant[i]) begin
        valid_q[i] <= 1'b1;
        lo_q[i]    <= pend_lo_q;
        hi_q[i]    <= cmd_addr_i;
      end else if (is_close && close_match[i]) begin
        valid_q[i] <= 1'b0;
      end
    end
  end

  assign probe_hit_o = |in_rng;
  assign overflow_o  = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q  <= 1'b0;
      pend_lo_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (is_lo) begin
        pend_v_q  <= 1'b1;
        pend_lo_q <= cmd_addr_i;
      end else if (is_hi) begin
        pend_v_q <= 1'b0;
      end
      if (do_drop) ovf_q <= 1'b1;
    end
  end

  p_orphan_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_hi && !pend_v_q) |=> (valid_q == $past(valid_q)) && (ovf_q == $past(ovf_q)));

  p_close_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_close && (|close_match)) |=> ($countones(valid_q) < $past($countones(valid_q))));

  p_alloc_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/iwt_fill.sv
module iwt_fill #(
  parameter int LA_W   = 27,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      trig_i,
  input  logic [LA_W-1:0]           trig_addr_i,
  input  logic [BEATS*BEAT_W-1:0]   trig_line_i,
  input  logic                      trig_refresh_i,
  output logic                      busy_o,
  output logic                      fill_valid_o,
  input  logic                      fill_ready_i,
  output logic [LA_W-1:0]           fill_line_addr_o,
  output logic [$clog2(BEATS)-1:0]  fill_beat_o,
  output logic [BEAT_W-1:0]         fill_data_o,
  output logic                      fill_last_o,
  output logic                      fill_refresh_o
);
  localparam int BW     = $clog2(BEATS);
  localparam int LINE_W = BEATS * BEAT_W;

  logic              busy_q, refresh_q;
  logic [BW-1:0]     beat_q;
  logic [LA_W-1:0]   addr_q;
  logic [LINE_W-1:0] line_q;
  logic              last;

  assign last = (beat_q == BW'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      refresh_q <= 1'b0;
      beat_q    <= '0;
      addr_q    <= '0;
      line_q    <= '0;
    end else if (busy_q) begin
      if (fill_ready_i) begin
        if (last) begin
          busy_q <= 1'b0;
          beat_q <= '0;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end else if (trig_i) begin
      busy_q    <= 1'b1;
      beat_q    <= '0;
      addr_q    <= trig_addr_i;
      line_q    <= trig_line_i;
      refresh_q <= trig_refresh_i;
    end
  end

  assign busy_o           = busy_q;
  assign fill_valid_o     = busy_q;
  assign fill_line_addr_o = addr_q;
  assign fill_beat_o      = beat_q;
  assign fill_data_o      = line_q[beat_q*BEAT_W +: BEAT_W];
  assign fill_last_o      = busy_q && last;
  assign fill_refresh_o   = refresh_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && !fill_ready_i) |=> fill_valid_o && $stable(fill_beat_o) && $stable(fill_data_o));

  p_beat_seq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && fill_ready_i && !fill_last_o) |=> (fill_beat_o == $past(fill_beat_o) + 1'b1));

  p_first_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_valid_o) |-> (fill_beat_o == '0));
endmodule

// File: rtl/inj_window_table.sv
module inj_window_table
  import iwt_pkg::*;
#(
  parameter int NUM_WIN = 128,
  parameter int LA_W    = 27,
  parameter int BEAT_W  = 64,
  parameter int BEATS   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [1:0]                cmd_op_i,
  input  logic [LA_W-1:0]           cmd_addr_i,
  input  logic                      snoop_valid_i,
  input  logic [1:0]                snoop_kind_i,
  input  logic                      snoop_own_i,
  input  logic [LA_W-1:0]           snoop_addr_i,
  input  logic [BEATS*BEAT_W-1:0]   snoop_line_i,
  input  logic [1:0]                line_state_i,
  output logic                      snoop_hit_o,
  output logic                      fill_valid_o,
  input  logic                      fill_ready_i,
  output logic [LA_W-1:0]           fill_line_addr_o,
  output logic [$clog2(BEATS)-1:0]  fill_beat_o,
  output logic [BEAT_W-1:0]         fill_data_o,
  output logic                      fill_last_o,
  output logic                      fill_refresh_o,
  output logic                      overflow_o
);
  logic        tbl_hit, busy, trig, kind_ok, refresh;
  snoop_kind_e kind;
  line_state_e lstate;

  assign kind   = snoop_kind_e'(snoop_kind_i);
  assign lstate = line_state_e'(line_state_i);

  iwt_win_array #(.NUM_WIN(NUM_WIN), .LA_W(LA_W)) u_tbl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_addr_i   (cmd_addr_i),
    .probe_addr_i (snoop_addr_i),
    .probe_hit_o  (tbl_hit),
    .overflow_o   (overflow_o)
  );

  assign snoop_hit_o = snoop_valid_i && tbl_hit;

  // Invalid copy: any data transaction installs; Shared copy: only pushes refresh
  always_comb begin
    kind_ok = 1'b0;
    unique case (lstate)
      LS_INV:  kind_ok = (kind != SNP_OTHER);
      LS_SHR:  kind_ok = (kind == SNP_UPDATE) || (kind == SNP_STORE_UPD);
      default: kind_ok = 1'b0;
    endcase
  end

  assign refresh = (lstate == LS_SHR);
  assign trig    = snoop_hit_o && !snoop_own_i && kind_ok && !busy;

  iwt_fill #(.LA_W(LA_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_fill (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .trig_i           (trig),
    .trig_addr_i      (snoop_addr_i),
    .trig_line_i      (snoop_line_i),
    .trig_refresh_i   (refresh),
    .busy_o           (busy),
    .fill_valid_o     (fill_valid_o),
    .fill_ready_i     (fill_ready_i),
    .fill_line_addr_o (fill_line_addr_o),
    .fill_beat_o      (fill_beat_o),
    .fill_data_o      (fill_data_o),
    .fill_last_o      (fill_last_o),
    .fill_refresh_o   (fill_refresh_o)
  );

  p_inject_needs_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_valid_o) |-> ($past(snoop_hit_o) && !$past(snoop_own_i)));

  p_refresh_on_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fill_valid_o) && fill_refresh_o) |->
      ($past(line_state_i) == LS_SHR) && ($past(snoop_kind_i) != SNP_RD_REPLY));

  p_no_fill_owned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_valid_o) |-> ($past(line_state_i) != LS_EXC) && ($past(line_state_i) != LS_MOD));

  p_busy_keeps_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && !(fill_ready_i && fill_last_o)) |=> $stable(fill_line_addr_o) && $stable(fill_refresh_o));
endmodule

// File: tb/inj_window_table_bench.sv
`timescale 1ns/1ps
module inj_window_table_bench;
  localparam int NW = 4;
  localparam int AW = 16;
  localparam int BWD = 64;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cmd_valid = 0;
  logic [1:0]        cmd_op = 0;
  logic [AW-1:0]     cmd_addr = 0;
  logic              snv = 0;
  logic [1:0]        skind = 0;
  logic              sown = 0;
  logic [AW-1:0]     saddr = 0;
  logic [NB*BWD-1:0] sline = 0;
  logic [1:0]        lstate = 0;
  logic              ready = 1;
  logic              hit, fvalid, flast, frefresh, ovf;
  logic [AW-1:0]     faddr;
  logic [1:0]        fbeat;
  logic [BWD-1:0]    fdata;

  inj_window_table #(.NUM_WIN(NW), .LA_W(AW), .BEAT_W(BWD), .BEATS(NB)) u_inj_window_table (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .snoop_valid_i(snv), .snoop_kind_i(skind), .snoop_own_i(sown),
    .snoop_addr_i(saddr), .snoop_line_i(sline), .line_state_i(lstate),
    .snoop_hit_o(hit), .fill_valid_o(fvalid), .fill_ready_i(ready),
    .fill_line_addr_o(faddr), .fill_beat_o(fbeat), .fill_data_o(fdata),
    .fill_last_o(flast), .fill_refresh_o(frefresh), .overflow_o(ovf)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  bit          mv [NW];
  int          ml [NW];
  int          mh [NW];
  bit          mpend = 0;
  int          mpend_lo = 0;
  bit          movf = 0;
  bit          mbusy = 0;
  int          mbeat = 0;
  int          maddr = 0;
  bit          mref = 0;
  logic [NB*BWD-1:0] mline = 0;

  function automatic logic [NB*BWD-1:0] mk_line(input int a);
    logic [NB*BWD-1:0] l;
    for (int b = 0; b < NB; b++)
      l[b*BWD +: BWD] = {16'hC0DE, 16'(a), 16'(b), 16'(~a)};
    return l;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit cv, input int op, input int ca,
                      input bit sv, input int k, input bit own, input int sa,
                      input int ls, input bit rdy);
    bit eh, tr, free_found;
    cmd_valid = cv; cmd_op = 2'(op); cmd_addr = AW'(ca);
    snv = sv; skind = 2'(k); sown = own; saddr = AW'(sa); sline = mk_line(sa);
    lstate = 2'(ls); ready = rdy;
    #1;
    eh = 0;
    if (sv) for (int i = 0; i < NW; i++) if (mv[i] && ml[i] <= sa && sa <= mh[i]) eh = 1;
    chk(tag, "snoop_hit", hit, eh);
    chk(tag, "fill_valid", fvalid, mbusy);
    chk(tag, "overflow", ovf, movf);
    if (mbusy) begin
      chk(tag, "fill_addr", faddr, maddr);
      chk(tag, "fill_beat", fbeat, mbeat);
      chk(tag, "fill_data", fdata, mline[mbeat*BWD +: BWD]);
      chk(tag, "fill_last", flast, mbeat == NB-1);
      chk(tag, "fill_refresh", frefresh, mref);
    end
    // model advance
    tr = eh && !own && !mbusy &&
         ((ls == 0 && k != 3) || (ls == 1 && (k == 1 || k == 2)));
    if (mbusy) begin
      if (rdy) begin
        if (mbeat == NB-1) begin mbusy = 0; mbeat = 0; end
        else mbeat++;
      end
    end else if (tr) begin
      mbusy = 1; mbeat = 0; maddr = sa; mline = mk_line(sa); mref = (ls == 1);
    end
    if (cv) begin
      if (op == 1) begin mpend = 1; mpend_lo = ca; end
      else if (op == 2 && mpend) begin
        mpend = 0;
        free_found = 0;
        for (int i = 0; i < NW; i++)
          if (!mv[i] && !free_found) begin
            mv[i] = 1; ml[i] = mpend_lo; mh[i] = ca; free_found = 1;
          end
        if (!free_found) movf = 1;
      end else if (op == 3) begin
        for (int i = 0; i < NW; i++) if (mv[i] && ml[i] == ca) mv[i] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0, rdy);
  endtask

  task automatic cmd(input string tag, input int op, input int a);
    step(tag, 1, op, a, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic probe(input string tag, input int a);
    // kind 3 never injects, so this only observes the hit
    step(tag, 0, 0, 0, 1, 3, 0, a, 0, 1);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin mv[i] = 0; ml[i] = 0; mh[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle("R1", 2, 1);
    probe("R1", 'h100);

    // R3: high bound with no low
    cmd("R3", 2, 'h100);
    probe("R3", 'h100);
    chk("R3", "overflow_after_orphan", ovf, 0);

    // R2: low replaced, then window [0x110,0x11F]
    cmd("R2", 1, 'h100);
    cmd("R2", 1, 'h110);
    cmd("R2", 2, 'h11F);
    probe("R2", 'h10F);
    probe("R2", 'h110);
    probe("R2", 'h11F);
    probe("R2", 'h120);

    // R11: same-cycle open-high and snoop
    cmd("R11", 1, 'h200);
    step("R11", 1, 2, 'h200, 1, 3, 0, 'h200, 0, 1);
    probe("R11", 'h200);

    // R6 + R9: read reply injection, ready held high
    step("R6", 0, 0, 0, 1, 0, 0, 'h115, 0, 1);
    idle("R9", 5, 1);

    // R8: cases that must not inject
    step("R8", 0, 0, 0, 1, 0, 0, 'h115, 1, 1);
    step("R8", 0, 0, 0, 1, 1, 0, 'h115, 2, 1);
    step("R8", 0, 0, 0, 1, 2, 0, 'h115, 3, 1);
    step("R8", 0, 0, 0, 1, 1, 1, 'h115, 0, 1);
    step("R8", 0, 0, 0, 1, 3, 0, 'h115, 0, 1);
    step("R8", 0, 0, 0, 1, 1, 0, 'h300, 0, 1);
    idle("R8", 2, 1);

    // R7 + R9 + R10: refresh of a shared line, ready toggling, snoops while busy
    step("R7", 0, 0, 0, 1, 1, 0, 'h112, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 2, 0, 'h113, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 0, 'h114, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R10", 0, 0, 0, 1, 1, 0, 'h116, 0, 1);
    idle("R10", 2, 1);

    // R7: store-update into invalid line
    step("R7", 0, 0, 0, 1, 2, 0, 'h200, 0, 1);
    idle("R7", 5, 1);

    // R4: fill the table, then overflow
    cmd("R4", 1, 'h400); cmd("R4", 2, 'h40F);
    cmd("R4", 1, 'h500); cmd("R4", 2, 'h50F);
    chk("R4", "overflow_before_full", ovf, 0);
    cmd("R4", 1, 'h600); cmd("R4", 2, 'h60F);
    probe("R4", 'h605);
    idle("R4", 2, 1);
    chk("R4", "overflow_sticky", ovf, 1);

    // R5: close and reuse
    cmd("R5", 3, 'h110);
    probe("R5", 'h115);
    probe("R5", 'h405);
    cmd("R5", 1, 'h600); cmd("R5", 2, 'h60F);
    probe("R5", 'h605);
    step("R5", 0, 0, 0, 1, 0, 0, 'h115, 0, 1);
    idle("R5", 3, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule